// File: doc/BRIEF.md
# Four-Operation ALU with Overflow Detection

This block is an N-bit arithmetic and logic unit that computes one of four operations on two operands: bitwise AND, bitwise OR, addition and subtraction. Both arithmetic operations share a single ripple-carry chain of one-bit full adders. For subtraction, every B bit passes through an XOR gate that acts as a conditional inverter, and the carry into the lowest stage is forced to 1. The inverted B plus one is therefore the two's complement of B.

Alongside the result, the unit reports the raw carry out of the top adder stage and a signed overflow flag. The overflow flag is the disagreement between the carry entering and the carry leaving the most significant stage. A data multiplexer steered by the 2-bit operation select picks the result. A thin registered wrapper captures all three outputs on each rising clock edge, so the combinational datapath can be used inside a clocked pipeline.

Top module: `alu4op_reg`

## Requirements
- R1: With select code 2'b00 the captured result is the bitwise AND of the two operands.
- R2: With select code 2'b01 the captured result is the bitwise OR of the two operands.
- R3: With select code 2'b10 the captured result is (A + B) modulo 2^N, and the carry flag equals bit N of the unsigned sum A + B.
- R4: With select code 2'b11 the captured result is (A - B) modulo 2^N, and the carry flag is 1 exactly when A >= B as unsigned values (no borrow).
- R5: During addition the overflow flag is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R6: During subtraction the overflow flag is 1 exactly when the operands' sign bits differ and the result's sign bit differs from that of A.
- R7: For the AND and OR codes both the carry flag and the overflow flag are 0.
- R8: Outputs are registered: the values computed from the inputs present at a rising clock edge appear just after that edge and hold until the next one.
- R9: While the internally synchronised reset is active (asserted asynchronously by rst_n low), the result, carry and overflow outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| op_sel | input | 2 | Operation select: 00 AND, 01 OR, 10 ADD, 11 SUB |
| res_q | output | WIDTH | Registered result |
| cout_q | output | 1 | Registered carry out of the top adder stage (0 for logic codes) |
| ovf_q | output | 1 | Registered signed overflow flag (0 for logic codes) |

## Verification
The bench builds two copies of the block, one with WIDTH = 4 and one with WIDTH = 16. At four bits every operand pair under every select code can be applied. This covers every combination of top-bit carry-in and carry-out, and so every overflow case of both arithmetic operations. The 16-bit copy takes a table of hand-derived corner vectors: the most positive plus one, the most negative plus itself, all ones plus one, zero minus one, and the most negative minus one. It also takes a stream of pseudo-random operands, which exercises long carry ripples at a realistic width.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } alu_op_e;

endpackage

// File: rtl/alu_fa.sv
module alu_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  logic half;

  always_comb begin
    half = x ^ y;
    s    = half ^ ci;
    co   = (x & y) | (half & ci);
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             c_msb_in,
  output logic             c_msb_out
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] b_cond;

  assign carry[0] = sub;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_stage
      assign b_cond[g] = b[g] ^ sub;
      alu_fa u_fa (
        .x  (a[g]),
        .y  (b_cond[g]),
        .ci (carry[g]),
        .s  (sum[g]),
        .co (carry[g+1])
      );
    end
  endgenerate

  assign c_msb_in  = carry[MSB];
  assign c_msb_out = carry[WIDTH];

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] y,
  output logic             carry,
  output logic             ovf
);

  logic             do_sub;
  logic             is_arith;
  logic [WIDTH-1:0] arith_sum;
  logic             c_top_in;
  logic             c_top_out;

  assign do_sub   = op[1] & op[0];
  assign is_arith = op[1];

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a         (a),
    .b         (b),
    .sub       (do_sub),
    .sum       (arith_sum),
    .c_msb_in  (c_top_in),
    .c_msb_out (c_top_out)
  );

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      default: y = arith_sum;
    endcase
    carry = is_arith & c_top_out;
    ovf   = is_arith & (c_top_in ^ c_top_out);
  end

endmodule

// File: rtl/alu4op_reg.sv
module alu4op_reg
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] res_q,
  output logic             cout_q,
  output logic             ovf_q
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [WIDTH-1:0] res_d;
  logic             cout_d;
  logic             ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe[1];

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a     (op_a),
    .b     (op_b),
    .op    (alu_op_e'(op_sel)),
    .y     (res_d),
    .carry (cout_d),
    .ovf   (ovf_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      cout_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      cout_q <= cout_d;
      ovf_q  <= ovf_d;
    end
  end

endmodule

// File: rtl/alu4op_chk.sv
module alu4op_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       op_sel,
  input logic [WIDTH-1:0] res_q,
  input logic             cout_q,
  input logic             ovf_q
);

  localparam int MSB = WIDTH - 1;

  assert_and_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(op_sel) == 2'b00) |-> res_q == ($past(op_a) & $past(op_b)));

  assert_or_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(op_sel) == 2'b01) |-> res_q == ($past(op_a) | $past(op_b)));

  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(op_sel) == 2'b10) |->
      {cout_q, res_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}));

  assert_sub_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(op_sel) == 2'b11) |->
      (res_q == WIDTH'($past(op_a) - $past(op_b)) && cout_q == ($past(op_a) >= $past(op_b))));

  assert_add_overflow_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(op_sel) == 2'b10) |->
      ovf_q == (($past(op_a[MSB]) == $past(op_b[MSB])) && (res_q[MSB] != $past(op_a[MSB]))));

  assert_sub_overflow_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(op_sel) == 2'b11) |->
      ovf_q == (($past(op_a[MSB]) != $past(op_b[MSB])) && (res_q[MSB] != $past(op_a[MSB]))));

  assert_logic_flags_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$past(op_sel[1])) |-> (!cout_q && !ovf_q));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $stable(op_a) && $stable(op_b) && $stable(op_sel)) |=> $stable(res_q));

  assert_reset_R9: assert property (@(posedge clk)
    !rst_sync_n |-> (res_q == '0 && !cout_q && !ovf_q));

endmodule

bind alu4op_reg alu4op_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_a       (op_a),
  .op_b       (op_b),
  .op_sel     (op_sel),
  .res_q      (res_q),
  .cout_q     (cout_q),
  .ovf_q      (ovf_q)
);

// File: tb/alu4op_reg_test.sv
module alu4op_reg_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] a, b;
  logic [1:0]  op;
  logic [15:0] w_res;
  logic        w_cout, w_ovf;
  logic [3:0]  na, nb;
  logic [1:0]  nop;
  logic [3:0]  n_res;
  logic        n_cout, n_ovf;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu4op_reg #(.WIDTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .op_sel(op),
    .res_q(w_res), .cout_q(w_cout), .ovf_q(w_ovf)
  );

  alu4op_reg #(.WIDTH(4)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .op_a(na), .op_b(nb), .op_sel(nop),
    .res_q(n_res), .cout_q(n_cout), .ovf_q(n_ovf)
  );

  // {a, b, op, res, cout, ovf} for the 16-bit instance
  localparam logic [51:0] VEC [10] = '{
    {16'h7FFF, 16'h0001, 2'b10, 16'h8000, 1'b0, 1'b1},
    {16'h8000, 16'h8000, 2'b10, 16'h0000, 1'b1, 1'b1},
    {16'hFFFF, 16'h0001, 2'b10, 16'h0000, 1'b1, 1'b0},
    {16'hC000, 16'hC000, 2'b10, 16'h8000, 1'b1, 1'b0},
    {16'h0000, 16'h0001, 2'b11, 16'hFFFF, 1'b0, 1'b0},
    {16'h8000, 16'h0001, 2'b11, 16'h7FFF, 1'b1, 1'b1},
    {16'h7FFF, 16'hFFFF, 2'b11, 16'h8000, 1'b0, 1'b1},
    {16'h1234, 16'h1234, 2'b11, 16'h0000, 1'b1, 1'b0},
    {16'hF0F0, 16'h0FF0, 2'b00, 16'h00F0, 1'b0, 1'b0},
    {16'hF0F0, 16'h0F0F, 2'b01, 16'hFFFF, 1'b0, 1'b0}
  };

  // returns {ovf, cout, res} with res zero above bit w-1
  function automatic logic [17:0] model(int w, logic [15:0] x, logic [15:0] y, logic [1:0] o);
    logic [16:0] mask, s;
    logic [15:0] r;
    logic c, v;
    mask = (17'h1 << w) - 17'h1;
    c = 1'b0;
    v = 1'b0;
    case (o)
      2'b00: r = x & y;
      2'b01: r = x | y;
      2'b10: begin
        s = {1'b0, x} + {1'b0, y};
        r = s[15:0] & mask[15:0];
        c = s[w];
        v = (x[w-1] == y[w-1]) && (r[w-1] != x[w-1]);
      end
      default: begin
        s = {1'b0, x} + ({1'b0, ~y} & mask) + 17'h1;
        r = s[15:0] & mask[15:0];
        c = s[w];
        v = (x[w-1] != y[w-1]) && (r[w-1] != x[w-1]);
      end
    endcase
    return {v, c, r};
  endfunction

  function automatic string tag_of(logic [1:0] o);
    case (o)
      2'b00:   return "R1 R7 R8";
      2'b01:   return "R2 R7 R8";
      2'b10:   return "R3 R5 R8";
      default: return "R4 R6 R8";
    endcase
  endfunction

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got ovf,cout,res=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    a = 16'hFFFF; b = 16'h0001; op = 2'b10;
    na = 4'hF; nb = 4'h1; nop = 2'b10;
    repeat (3) @(negedge clk);
    // R9: outputs cleared while reset held
    check("R9 wide", {w_ovf, w_cout, w_res}, 18'h0);
    check("R9 narrow", {n_ovf, n_cout, 12'h0, n_res}, 18'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed 16-bit vectors (R1..R6, R8)
    for (int i = 0; i < 10; i++) begin
      logic [51:0] v;
      v = VEC[i];
      a = v[51:36]; b = v[35:20]; op = v[19:18];
      @(negedge clk);
      check({"vector ", tag_of(op)}, {w_ovf, w_cout, w_res}, {v[0], v[1], v[17:2]});
    end

    // exhaustive 4-bit sweep
    for (int o = 0; o < 4; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          na = 4'(x); nb = 4'(y); nop = 2'(o);
          @(negedge clk);
          check({"narrow ", tag_of(2'(o))}, {n_ovf, n_cout, 12'h0, n_res},
                model(4, {12'h0, 4'(x)}, {12'h0, 4'(y)}, 2'(o)));
        end
      end
    end

    // random 16-bit operands
    for (int k = 0; k < 400; k++) begin
      a = 16'($urandom); b = 16'($urandom); op = 2'(k);
      @(negedge clk);
      check({"random ", tag_of(op)}, {w_ovf, w_cout, w_res}, model(16, a, b, op));
    end

    // R8: outputs hold while inputs stay put, then follow a change one edge later
    a = 16'h0003; b = 16'h0005; op = 2'b10;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold", {w_ovf, w_cout, w_res}, {2'b00, 16'h0008});
    op = 2'b00;
    #1;
    check("R8 no change before edge", {w_ovf, w_cout, w_res}, {2'b00, 16'h0008});
    @(negedge clk);
    check("R8 R1 after edge", {w_ovf, w_cout, w_res}, {2'b00, 16'h0001});

    // R9: asynchronous reset mid-cycle clears at once
    a = 16'h7FFF; b = 16'h0001; op = 2'b10;
    @(negedge clk);
    check("R5 before reset", {w_ovf, w_cout, w_res}, {2'b10, 16'h8000});
    #2 rst_n = 1'b0;
    #1;
    check("R9 async wide", {w_ovf, w_cout, w_res}, 18'h0);
    check("R9 async narrow", {n_ovf, n_cout, 12'h0, n_res}, 18'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 held through sync release", {w_ovf, w_cout, w_res}, 18'h0);
    repeat (3) @(negedge clk);
    check("R3 R5 after reset", {w_ovf, w_cout, w_res}, {2'b10, 16'h8000});

    done = 1'b1;
    finish_run();
  end

endmodule